// File: doc/BRIEF.md
# Read-Triggered Texture Pixel Blitter

This block moves one texture pixel into a background frame buffer each time the host reads a word inside a blit window. Before blitting, the host writes a source X coordinate, a source Y coordinate and a step for each into a small write-only register file. Both coordinates are fixed point, with eight fraction bits.

An accepted read takes the integer parts of the coordinates and forms a texture address from them. It fetches a pen from a synchronous texture ROM and keeps the low 15 bits. If the pen is not zero, it writes the pen to the back frame buffer at the word offset of the read. Both coordinates then advance by their steps, ready for the next read.

A separate control register chooses which of the two frame buffers is the back buffer. The read data is always zero. The read completes with a one-cycle ready pulse after a fixed latency that covers the ROM access.

Top module: `tex_blit`

## Requirements
- R1: After reset, all four coordinate registers and the buffer select are zero, and `fb_we` and `rd_ready` are low. A blit issued with no register writes fetches texture address 0 and writes to buffer 0.
- R2: A register write with `reg_addr` 0, 1, 2 or 3 loads source X, X step, source Y or Y step from `reg_wdata`.
- R3: The texture address is ((X >> 8) & 0x1FF) + ((Y >> 8) << 9), formed at full width.
- R4: The texture address is reduced modulo ROM_WORDS before it drives `rom_addr`.
- R5: Only bits 14:0 of `rom_data` form the pen. Bit 15 never reaches `fb_data` and never makes a pen count as non-zero.
- R6: A pen of zero is transparent: `fb_we` stays low for that blit.
- R7: A non-zero pen is written with `fb_addr` equal to the `rd_off` that came with the triggering read.
- R8: `fb_sel` equals bit 6 of the last value written through `ctl_we`.
- R9: After each blit, X becomes X + X step and Y becomes Y + Y step, each modulo 2^32. The next blit uses the new values.
- R10: An accepted read gives exactly one `rd_ready` pulse, on the third rising edge after the accepting edge. `fb_we` can only be high in that same cycle, and `rd_data` is always zero.
- R11: When a host register write lands on the same edge as the coordinate step update, the written value wins for that register. The other coordinate still steps.
- R12: `rd_req` is ignored while a blit is in progress. It causes no extra fetch, no extra ready pulse and no extra step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Coordinate register write strobe |
| reg_addr | input | 2 | Register index: 0 X, 1 X step, 2 Y, 3 Y step |
| reg_wdata | input | 32 | Register write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control data; bit 6 selects the back buffer |
| rd_req | input | 1 | Blit-window read strobe |
| rd_off | input | OFF_W | Word offset of the read |
| rd_ready | output | 1 | Read completion pulse |
| rd_data | output | 32 | Read data, always zero |
| rom_en | output | 1 | Texture ROM read enable |
| rom_addr | output | ROM_AW | Texture ROM word address |
| rom_data | input | 16 | Texture ROM data, valid one cycle after `rom_en` |
| fb_we | output | 1 | Frame buffer write enable |
| fb_sel | output | 1 | Target buffer index |
| fb_addr | output | OFF_W | Frame buffer word offset |
| fb_data | output | 15 | Pen written |

## Verification
A host register write and the step write-back can fall on the same clock edge. The bench provokes this by holding a write to source X during the cycle in which the blit completes. It then judges the result from the next blit's texture fetch, which must use the written X together with the stepped Y. Besides this, the bench sweeps several coordinate and step patterns, including fractional steps, negative steps and a Y large enough to force the ROM modulo. A ROM model returns transparent pens and pens with bit 15 set, and every blit's write is compared against arithmetic in the bench.

// File: rtl/tex_blit.sv
module tex_blit #(
  parameter int ROM_WORDS = 4096,
  parameter int OFF_W     = 17,
  parameter int ROM_AW    = $clog2(ROM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              rd_req,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              rd_ready,
  output logic [31:0]       rd_data,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [15:0]       rom_data,
  output logic              fb_we,
  output logic              fb_sel,
  output logic [OFF_W-1:0]  fb_addr,
  output logic [14:0]       fb_data
);
  localparam logic [32:0] ROM_LEN = 33'(ROM_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_ROM, S_DATA} state_t;
  state_t state;

  logic [31:0] x_q, dx_q, y_q, dy_q;
  logic [OFF_W-1:0] off_q;
  logic bank;
  logic [32:0] lin, lin_mod;
  logic [14:0] pen;
  logic step;

  assign lin     = {24'd0, x_q[16:8]} + ({9'd0, y_q[31:8]} << 9);
  assign lin_mod = lin % ROM_LEN;
  assign pen     = rom_data[14:0];
  assign step    = (state == S_DATA);
  assign rom_en  = (state == S_ROM);
  assign rd_data = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      x_q      <= '0;
      dx_q     <= '0;
      y_q      <= '0;
      dy_q     <= '0;
      off_q    <= '0;
      bank     <= 1'b0;
      rom_addr <= '0;
      rd_ready <= 1'b0;
      fb_we    <= 1'b0;
      fb_sel   <= 1'b0;
      fb_addr  <= '0;
      fb_data  <= '0;
    end else begin
      rd_ready <= 1'b0;
      fb_we    <= 1'b0;
      if (ctl_we) bank <= ctl_wdata[6];
      case (state)
        S_IDLE: if (rd_req) begin
          off_q    <= rd_off;
          rom_addr <= lin_mod[ROM_AW-1:0];
          state    <= S_ROM;
        end
        S_ROM: state <= S_DATA;
        default: begin
          state    <= S_IDLE;
          rd_ready <= 1'b1;
          fb_we    <= |pen;
          fb_data  <= pen;
          fb_addr  <= off_q;
          fb_sel   <= bank;
        end
      endcase
      if (step) begin
        x_q <= x_q + dx_q;
        y_q <= y_q + dy_q;
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: x_q  <= reg_wdata;
          2'd1: dx_q <= reg_wdata;
          2'd2: y_q  <= reg_wdata;
          default: dy_q <= reg_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/tex_blit_chk.sv
module tex_blit_chk #(
  parameter int OFF_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_ready,
  input logic [31:0]      rd_data,
  input logic             rom_en,
  input logic             fb_we,
  input logic [14:0]      fb_data,
  input logic [OFF_W-1:0] fb_addr,
  input logic [OFF_W-1:0] rd_off
);
  p_data_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == 32'd0);
  p_ready_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> $past(rom_en, 2));
  p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);
  p_write_in_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> rd_ready);
  p_no_clear_pen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> fb_data != 15'd0);
  p_single_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> !rom_en);
  p_same_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> fb_addr == $past(rd_off, 3));
endmodule

bind tex_blit tex_blit_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready), .rd_data(rd_data),
  .rom_en(rom_en), .fb_we(fb_we), .fb_data(fb_data), .fb_addr(fb_addr),
  .rd_off(rd_off)
);

// File: tb/tex_blit_test.sv
module tex_blit_test;
  localparam int ROM_WORDS = 1500;
  localparam int OFF_W = 8;
  localparam int ROM_AW = $clog2(ROM_WORDS);

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic ctl_we = 0; logic [7:0] ctl_wdata = 0;
  logic rd_req = 0; logic [OFF_W-1:0] rd_off = 0;
  logic rd_ready, rom_en, fb_we, fb_sel;
  logic [31:0] rd_data;
  logic [ROM_AW-1:0] rom_addr;
  logic [15:0] rom_data;
  logic [OFF_W-1:0] fb_addr;
  logic [14:0] fb_data;

  int errors = 0, checks = 0;
  logic [31:0] mx = 0, mdx = 0, my = 0, mdy = 0;
  logic mbank = 0;

  always #2.5 clk = ~clk;

  tex_blit #(.ROM_WORDS(ROM_WORDS), .OFF_W(OFF_W)) uut (.*);

  function automatic logic [15:0] pen_of(input int a);
    if (a % 7 == 0) return 16'h8000;
    return {a[0], 15'((a * 37) % 32767 + 1)};
  endfunction

  always @(posedge clk) rom_data <= pen_of(int'(rom_addr));

  function automatic int exp_addr(input logic [31:0] x, input logic [31:0] y);
    longint lin;
    lin = longint'((x >> 8) & 32'h1FF) + (longint'(y >> 8) << 9);
    return int'(lin % ROM_WORDS);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    case (a) 0: mx = d; 1: mdx = d; 2: my = d; default: mdy = d; endcase
  endtask

  task automatic ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
    mbank = d[6];
  endtask

  // one blit; optional collision write on the completion edge (R11) and busy re-request (R12)
  task automatic blit(input logic [OFF_W-1:0] off, input bit collide, input logic [31:0] cval,
                      input bit busy_req);
    int n, a;
    logic [14:0] p;
    a = exp_addr(mx, my);
    p = pen_of(a)[14:0];
    @(negedge clk); rd_req = 1; rd_off = off;
    @(negedge clk); rd_req = busy_req; rd_off = ~off;
    n = 1;
    chk("R10", "no early ready", rd_ready, 0);
    @(negedge clk); rd_req = 0; n = 2;
    chk("R4", "rom address", rom_addr, a);
    if (collide) begin reg_we = 1; reg_addr = 0; reg_wdata = cval; end
    chk("R10", "no early ready", rd_ready, 0);
    @(negedge clk); n = 3; reg_we = 0;
    chk("R10", "ready latency", rd_ready, 1);
    chk("R10", "read data", rd_data, 0);
    chk("R6", "write enable", fb_we, p != 0);
    if (p != 0) begin
      chk("R5", "pen", fb_data, p);
      chk("R7", "offset", fb_addr, off);
      chk("R8", "buffer", fb_sel, mbank);
    end
    @(negedge clk);
    chk("R12", "single ready", rd_ready, 0);
    mx = collide ? cval : mx + mdx;
    my = my + mdy;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", rd_ready, 0);
    chk("R1", "reset fb_we", fb_we, 0);
    rst_n = 1;
    // R1: default coords address 0 (pen transparent) - then step zero
    blit(8'h05, 0, 0, 0);
    // R2/R3/R9 sweeps
    wr(0, 32'h0000_0100); wr(1, 32'h0000_0100); wr(2, 0); wr(3, 0);
    for (int i = 0; i < 20; i++) blit(8'(i), 0, 0, 0);
    ctl(8'h40);
    wr(0, 32'h0001_FF80); wr(1, 32'h0000_0040); wr(2, 32'h0000_0300); wr(3, 32'h0000_0180);
    for (int i = 0; i < 20; i++) blit(8'(i * 3), 0, 0, 0);
    ctl(8'hBF);
    wr(0, 32'h0000_0500); wr(1, 32'hFFFF_FF00); wr(2, 32'h0100_0000); wr(3, 32'h0001_2345);
    for (int i = 0; i < 20; i++) blit(8'(255 - i), 0, 0, 0);
    ctl(8'h40);
    // R11: collision of host write with step update
    wr(0, 32'h0000_0300); wr(1, 32'h0000_0100); wr(2, 32'h0000_0200); wr(3, 32'h0000_0100);
    blit(8'h11, 1, 32'h0000_2A00, 0);
    blit(8'h12, 0, 0, 0);
    blit(8'h13, 1, 32'h0000_0900, 0);
    blit(8'h14, 0, 0, 0);
    // R12: request while busy ignored
    blit(8'h21, 0, 0, 1);
    blit(8'h22, 0, 0, 1);
    blit(8'h23, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule